// File: doc/BRIEF.md
# Downstream Configuration Address Translator

This block sits on the primary side of a two-port bus bridge. It watches each primary address phase and picks out configuration cycles that are aimed at a device sitting directly on the secondary bus. When it finds one, it raises a forward request. It also produces the secondary-bus address for the matching single-target configuration cycle, and it passes the bus command through.

The address phase is the first clock in which FRAME# is low. For a hit, the block does four things to the address:

- It decodes the 5-bit device number into a one-hot select pattern on the upper sixteen address bits.
- It clears the device field.
- It clears the two low bits.
- It keeps the function and register fields unchanged.

The request, address and command stay latched until the surrounding control logic pulses the clear input. A miss leaves every output at zero. Cycles that start on the secondary side never trigger a translation.

Top module: `cfg_t1_xlate`

## Requirements
- R1: One clock edge after the first cycle with `frame_n` low, `fwd_req` goes to 1 if all of the following hold: `pri_ad[1:0]` is 2'b01, `pri_cbe` is 4'b1010 (configuration read) or 4'b1011 (configuration write), `pri_ad[23:16]` equals `sec_bus_num`, and `origin_sec` is 0.
- R2: When `pri_ad[23:16]` differs from `sec_bus_num`, there is no request, and `sec_ad` and `sec_cbe` stay at zero.
- R3: When the command is not 4'b1010 or 4'b1011, or when `pri_ad[1:0]` is not 2'b01, there is no request and the outputs stay at zero.
- R4: An address phase seen while `origin_sec` is 1 never produces a request.
- R5: In a translated address, `sec_ad[1:0]` is 2'b00, `sec_ad[15:11]` is zero, and `sec_ad[10:2]` equals `pri_ad[10:2]`.
- R6: A device number `pri_ad[15:11]` in the range 0 to 15 sets only bit `sec_ad[16+device]` within `sec_ad[31:16]`.
- R7: A device number in the range 16 to 31 still raises `fwd_req`, but leaves `sec_ad[31:16]` all zero.
- R8: Once `fwd_req` is set, `fwd_req`, `sec_ad` and `sec_cbe` hold their values until `fwd_clr` is 1 at a clock edge. Address phases that arrive in the meantime are ignored. If `fwd_clr` and a new address phase fall on the same edge, the clear wins.
- R9: While `fwd_req` is 1, `sec_cbe` equals the command that was latched.
- R10: After reset, `fwd_req`, `sec_ad` and `sec_cbe` are all zero.
- R11: Only the high-to-low transition of `frame_n` counts as an address phase. While `frame_n` stays low after a clear, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low cycle frame; the first low cycle is the address phase |
| origin_sec | input | 1 | 1 when the current cycle was started on the secondary side |
| pri_ad | input | 32 | Primary address/data lines |
| pri_cbe | input | 4 | Primary command/byte-enable lines |
| sec_bus_num | input | 8 | Programmed number of the secondary bus |
| fwd_clr | input | 1 | Pulse to release a latched request |
| fwd_req | output | 1 | A translated configuration cycle is waiting to go downstream |
| sec_ad | output | 32 | Translated address for the secondary bus |
| sec_cbe | output | 4 | Command to issue on the secondary bus |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit bus number, a 5-bit device field and the select pattern starting at bit 16. It sweeps all 32 device numbers, which covers both the one-hot decode range and the range that selects no device. It programs the bus number to 0, 0x5A and 0xFF to exercise matching at both ends of the field. It also places address phases on the same edge as a clear and during a held request, so that clear priority and the hold behaviour are observed at the ports.

// File: rtl/cfg_t1_xlate.sv
module cfg_t1_xlate #(
  parameter int AD_W      = 32,
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int DEV_LSB   = 11,
  parameter int BUS_LSB   = 16,
  parameter int IDSEL_LSB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_n,
  input  logic            origin_sec,
  input  logic [AD_W-1:0] pri_ad,
  input  logic [3:0]      pri_cbe,
  input  logic [BUS_W-1:0] sec_bus_num,
  input  logic            fwd_clr,
  output logic            fwd_req,
  output logic [AD_W-1:0] sec_ad,
  output logic [3:0]      sec_cbe
);
  localparam int IDSEL_N = AD_W - IDSEL_LSB;
  localparam int GAP_W   = IDSEL_LSB - DEV_LSB;

  logic frame_q;
  logic [DEV_W-1:0] dev;
  logic [IDSEL_N-1:0] idsel;
  logic [AD_W-1:0] xl_ad;
  logic hit, addr_ph;

  assign addr_ph = frame_q & ~frame_n;
  assign dev     = pri_ad[DEV_LSB +: DEV_W];
  assign hit     = addr_ph & ~origin_sec & (pri_ad[1:0] == 2'b01)
                 & (pri_cbe[3:1] == 3'b101)
                 & (pri_ad[BUS_LSB +: BUS_W] == sec_bus_num);

  for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
    assign idsel[i] = (dev == DEV_W'(i));
  end

  assign xl_ad = {idsel, {GAP_W{1'b0}}, pri_ad[DEV_LSB-1:2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      fwd_req <= 1'b0;
      sec_ad  <= '0;
      sec_cbe <= '0;
    end else begin
      frame_q <= frame_n;
      if (fwd_clr) begin
        fwd_req <= 1'b0;
        sec_ad  <= '0;
        sec_cbe <= '0;
      end else if (!fwd_req && hit) begin
        fwd_req <= 1'b1;
        sec_ad  <= xl_ad;
        sec_cbe <= pri_cbe;
      end
    end
  end

  a_r1_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_req) |-> $past(pri_ad[1:0] == 2'b01 && pri_cbe[3:1] == 3'b101
                             && pri_ad[BUS_LSB +: BUS_W] == sec_bus_num));
  a_r4_no_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_req) |-> $past(!origin_sec));
  a_r5_low_fields: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> (sec_ad[1:0] == 2'b00 && sec_ad[IDSEL_LSB-1:DEV_LSB] == '0));
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sec_ad[AD_W-1:IDSEL_LSB]));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_req |-> (sec_ad == '0 && sec_cbe == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_req && !fwd_clr) |=> (fwd_req && $stable(sec_ad) && $stable(sec_cbe)));
  a_r9_cmd_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_req |-> (sec_cbe[3:1] == 3'b101));
endmodule

// File: tb/cfg_t1_xlate_test.sv
module cfg_t1_xlate_test;
  logic clk = 0, rst_n = 0, frame_n = 1, origin_sec = 0, fwd_clr = 0;
  logic [31:0] pri_ad = 0;
  logic [3:0] pri_cbe = 0;
  logic [7:0] sec_bus_num = 8'h5A;
  logic fwd_req;
  logic [31:0] sec_ad;
  logic [3:0] sec_cbe;
  int checks = 0, errors = 0;
  bit done = 0;

  cfg_t1_xlate uut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_addr(logic [7:0] bus, logic [4:0] dv, logic [2:0] fn, logic [5:0] rg);
    return {8'h00, bus, dv, fn, rg, 2'b01};
  endfunction

  function automatic logic [31:0] exp_addr(logic [4:0] dv, logic [2:0] fn, logic [5:0] rg);
    logic [15:0] sel = (dv < 16) ? (16'h1 << dv) : 16'h0;
    return {sel, 5'b0, fn, rg, 2'b00};
  endfunction

  task automatic phase(logic [31:0] ad, logic [3:0] cmd, logic sec);
    @(negedge clk);
    frame_n = 0; pri_ad = ad; pri_cbe = cmd; origin_sec = sec;
    @(negedge clk);
    frame_n = 1; origin_sec = 0;
  endtask

  task automatic clear();
    @(negedge clk); fwd_clr = 1;
    @(negedge clk); fwd_clr = 0;
  endtask

  task automatic t_reset();
    chk("R10", {fwd_req, sec_ad, sec_cbe}, 37'h0);
  endtask

  task automatic t_sweep();
    for (int d = 0; d < 32; d++) begin
      phase(cfg_addr(sec_bus_num, 5'(d), 3'(d), 6'(d * 3)), (d % 2) ? 4'hB : 4'hA, 0);
      chk(d < 16 ? "R1 R5 R6" : "R1 R5 R7", {fwd_req, sec_ad, sec_cbe},
          {1'b1, exp_addr(5'(d), 3'(d), 6'(d * 3)), (d % 2) ? 4'hB : 4'hA});
      clear();
    end
  endtask

  task automatic t_misses();
    phase(cfg_addr(8'h5B, 5'd3, 3'd1, 6'd4), 4'hA, 0);
    chk("R2", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    phase(cfg_addr(8'h5A, 5'd3, 3'd1, 6'd4), 4'h6, 0);
    chk("R3 cmd", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    phase(cfg_addr(8'h5A, 5'd3, 3'd1, 6'd4) & ~32'h1, 4'hB, 0);
    chk("R3 type0", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    phase(cfg_addr(8'h5A, 5'd3, 3'd1, 6'd4) | 32'h2, 4'hB, 0);
    chk("R3 ad11", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    phase(cfg_addr(8'h5A, 5'd3, 3'd1, 6'd4), 4'hA, 1);
    chk("R4", {fwd_req, sec_ad, sec_cbe}, 37'h0);
  endtask

  task automatic t_bus_edges();
    sec_bus_num = 8'h00;
    phase(cfg_addr(8'h00, 5'd15, 3'd7, 6'h3F), 4'hB, 0);
    chk("R1 bus0", {fwd_req, sec_ad, sec_cbe}, {1'b1, exp_addr(5'd15, 3'd7, 6'h3F), 4'hB});
    clear();
    sec_bus_num = 8'hFF;
    phase(cfg_addr(8'hFF, 5'd0, 3'd0, 6'd0), 4'hA, 0);
    chk("R1 busFF", {fwd_req, sec_ad, sec_cbe}, {1'b1, exp_addr(5'd0, 3'd0, 6'd0), 4'hA});
    clear();
    sec_bus_num = 8'h5A;
  endtask

  task automatic t_hold();
    phase(cfg_addr(8'h5A, 5'd2, 3'd1, 6'd9), 4'hA, 0);
    phase(cfg_addr(8'h5A, 5'd7, 3'd2, 6'd1), 4'hB, 0);
    chk("R8 ignore", {fwd_req, sec_ad, sec_cbe}, {1'b1, exp_addr(5'd2, 3'd1, 6'd9), 4'hA});
    chk("R9", {28'h0, sec_cbe}, 32'hA);
    repeat (5) @(negedge clk);
    chk("R8 stable", {fwd_req, sec_ad, sec_cbe}, {1'b1, exp_addr(5'd2, 3'd1, 6'd9), 4'hA});
    @(negedge clk);
    fwd_clr = 1; frame_n = 0; pri_ad = cfg_addr(8'h5A, 5'd4, 3'd0, 6'd0); pri_cbe = 4'hA;
    @(negedge clk);
    fwd_clr = 0;
    chk("R8 clear wins", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    repeat (3) @(negedge clk);
    chk("R11", {fwd_req, sec_ad, sec_cbe}, 37'h0);
    frame_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_misses();
    t_bus_edges();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule